// File: doc/BRIEF.md
# Dual-Phase Sine/Cosine NCO

This block is a numerically controlled oscillator for a digital down-converter. A 32-bit phase accumulator adds a signed phase increment on every clock. The upper bits of the accumulated phase address a sine/cosine table, which gives a 12-bit signed "even-time" cosine and sine pair. The multipliers of the mixer and the loop that produces the increment are outside this block.

In high-speed mode the mixer takes two real input samples per clock. For that case the block also looks up a second, "odd-time" pair at the phase halfway between the current and the next accumulator value, which is the accumulator plus half the increment. The direct tuning range in this mode is limited to plus or minus a quarter of the input sample rate. To tune beyond that range, the odd-negate control inverts both odd-time outputs. This shifts the mix by a further half of the input rate. A synchronous clear input resets the phase so that the oscillator can be aligned to an external event.

Top module: `dual_phase_nco`

## Requirements
- R1: On every clock edge out of reset, the 32-bit phase accumulator takes (accumulator + phaseInc) modulo 2^32. The even-time pair is looked up at accumulator bits [31:19].
- R2: For a 13-bit address a, the lookup returns sin = round(2047·sin(2π(a+0.5)/8192)) and cos = round(2047·cos(2π(a+0.5)/8192)), both as 12-bit two's complement.
- R3: The outputs are registered. The pair formed from the accumulator value and the inputs present at clock edge k appears on the outputs just after edge k+1, and all four outputs are aligned to the same cycle.
- R4: When sync is high at an edge, the accumulator becomes zero at that edge and the increment is not added. The lookup captured at that edge still uses the value held before the clear.
- R5: When highSpeed is high, the odd-time pair is looked up at bits [31:19] of (accumulator + (phaseInc arithmetically shifted right by one)) modulo 2^32.
- R6: When highSpeed is low, both odd-time outputs are zero.
- R7: When highSpeed and oddNegate are both high, both odd-time outputs are the two's-complement negation of the R5 lookup. When highSpeed is low, oddNegate has no effect on any output.
- R8: While rst_n is low, all four outputs are zero and the accumulator is zero.
- R9: No output ever takes the value -2048, so negation never overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Clears the phase accumulator |
| phaseInc | input | 32 | Signed phase increment per clock |
| highSpeed | input | 1 | Enables the odd-time lookup |
| oddNegate | input | 1 | Negates the odd-time outputs in high-speed mode |
| evenCos | output | 12 | Even-time cosine, signed |
| evenSin | output | 12 | Even-time sine, signed |
| oddCos | output | 12 | Odd-time cosine, signed |
| oddSin | output | 12 | Odd-time sine, signed |

## Verification
Fixed increments are used to tell the address paths apart:
- A zero increment makes the odd and even lookups coincide, so any fault in the negate path shows up directly.
- An increment of -1 checks that the half increment is shifted arithmetically and not logically.
- A quarter-turn, a half-turn and the largest positive increment test the quadrant folding and the modulo wrap.

Long random runs with a fixed seed then mix negative increments, sync pulses and mode switching against a bench model of the phase. These runs separate faults in pipeline alignment, clear priority and mode gating from faults in the table contents.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Strobes from control to datapath, valid for the current clock edge
  typedef struct packed {
    logic clearAcc;
    logic oddEn;
    logic oddNeg;
  } nco_ctrl_t;

  // Magnitude of the first-quadrant sine sample, half-step offset
  function automatic int quarterSinMag(input int idx, input int addrW, input int ampW);
    real peak;
    real ang;
    peak = real'((1 << (ampW - 1)) - 1);
    ang  = TWO_PI * (real'(idx) + 0.5) / real'(1 << addrW);
    return $rtoi(peak * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/nco_trig_lut.sv
module nco_trig_lut #(
  parameter int ADDR_W = 13,
  parameter int AMP_W  = 12
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [AMP_W-1:0]  sinOut,
  output logic signed [AMP_W-1:0]  cosOut
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAG_W = AMP_W - 1;
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(DEPTH);

  logic [MAG_W-1:0] romW [DEPTH];

  // Quarter-wave table filled at elaboration
  for (genvar j = 0; j < DEPTH; j++) begin : g_rom
    localparam int VAL = nco_pkg::quarterSinMag(j, ADDR_W, AMP_W);
    assign romW[j] = MAG_W'(VAL);
  end

  function automatic logic signed [AMP_W-1:0] foldLook(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] idx;
    logic [MAG_W-1:0] mag;
    logic signed [AMP_W-1:0] pos;
    idx = a[ADDR_W-2] ? ~a[IDX_W-1:0] : a[IDX_W-1:0];
    mag = romW[idx];
    pos = $signed({1'b0, mag});
    return a[ADDR_W-1] ? -pos : pos;
  endfunction

  logic [ADDR_W-1:0] cosAddr;
  assign cosAddr = addr + QUARTER;

  always_comb begin
    sinOut = foldLook(addr);
    cosOut = foldLook(cosAddr);
  end
endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl (
  input  logic               sync,
  input  logic               highSpeed,
  input  logic               oddNegate,
  output nco_pkg::nco_ctrl_t ctrl
);
  always_comb begin
    ctrl.clearAcc = sync;
    ctrl.oddEn    = highSpeed;
    ctrl.oddNeg   = highSpeed & oddNegate;
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 13,
  parameter int AMP_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  nco_pkg::nco_ctrl_t       ctrl,
  input  logic [PHASE_W-1:0]       phaseInc,
  output logic signed [AMP_W-1:0]  evenCos,
  output logic signed [AMP_W-1:0]  evenSin,
  output logic signed [AMP_W-1:0]  oddCos,
  output logic signed [AMP_W-1:0]  oddSin
);
  logic [PHASE_W-1:0]        acc;
  logic signed [PHASE_W-1:0] halfInc;
  logic [PHASE_W-1:0]        oddPhase;
  logic [ADDR_W-1:0]         evenAddrQ, oddAddrQ;
  logic                      oddEnQ, oddNegQ;
  logic signed [AMP_W-1:0]   lutEvenSin, lutEvenCos, lutOddSin, lutOddCos;

  assign halfInc  = $signed(phaseInc) >>> 1;
  assign oddPhase = acc + $unsigned(halfInc);

  // Phase accumulator
  always_ff @(posedge clk) begin
    if (!rst_n)             acc <= '0;
    else if (ctrl.clearAcc) acc <= '0;
    else                    acc <= acc + phaseInc;
  end

  // Address stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evenAddrQ <= '0;
      oddAddrQ  <= '0;
      oddEnQ    <= 1'b0;
      oddNegQ   <= 1'b0;
    end else begin
      evenAddrQ <= acc[PHASE_W-1 -: ADDR_W];
      oddAddrQ  <= oddPhase[PHASE_W-1 -: ADDR_W];
      oddEnQ    <= ctrl.oddEn;
      oddNegQ   <= ctrl.oddNeg;
    end
  end

  nco_trig_lut #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) evenLut_i (
    .addr(evenAddrQ), .sinOut(lutEvenSin), .cosOut(lutEvenCos)
  );
  nco_trig_lut #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) oddLut_i (
    .addr(oddAddrQ), .sinOut(lutOddSin), .cosOut(lutOddCos)
  );

  // Output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evenCos <= '0;
      evenSin <= '0;
      oddCos  <= '0;
      oddSin  <= '0;
    end else begin
      evenCos <= lutEvenCos;
      evenSin <= lutEvenSin;
      if (!oddEnQ) begin
        oddCos <= '0;
        oddSin <= '0;
      end else if (oddNegQ) begin
        oddCos <= -lutOddCos;
        oddSin <= -lutOddSin;
      end else begin
        oddCos <= lutOddCos;
        oddSin <= lutOddSin;
      end
    end
  end
endmodule

// File: rtl/dual_phase_nco.sv
module dual_phase_nco #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 13,
  parameter int AMP_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync,
  input  logic [PHASE_W-1:0]       phaseInc,
  input  logic                     highSpeed,
  input  logic                     oddNegate,
  output logic signed [AMP_W-1:0]  evenCos,
  output logic signed [AMP_W-1:0]  evenSin,
  output logic signed [AMP_W-1:0]  oddCos,
  output logic signed [AMP_W-1:0]  oddSin
);
  nco_pkg::nco_ctrl_t ctrl;

  nco_ctrl ctrl_i (
    .sync(sync), .highSpeed(highSpeed), .oddNegate(oddNegate), .ctrl(ctrl)
  );

  nco_datapath #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .phaseInc(phaseInc),
    .evenCos(evenCos), .evenSin(evenSin), .oddCos(oddCos), .oddSin(oddSin)
  );
endmodule

// File: rtl/dual_phase_nco_chk.sv
module dual_phase_nco_chk #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 13,
  parameter int AMP_W   = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sync,
  input logic [PHASE_W-1:0]       phaseInc,
  input logic                     highSpeed,
  input logic                     oddNegate,
  input logic signed [AMP_W-1:0]  evenCos,
  input logic signed [AMP_W-1:0]  evenSin,
  input logic signed [AMP_W-1:0]  oddCos,
  input logic signed [AMP_W-1:0]  oddSin
);
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;
  localparam int SIN0 = $rtoi(real'(PEAK) * $sin(3.141592653589793 / real'(1 << ADDR_W)) + 0.5);
  localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)         warm <= '0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  assert_odd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2 && !$past(highSpeed, 2)) |-> (oddCos == 0 && oddSin == 0));

  assert_sync_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3 && $past(sync, 3)) |-> (evenCos == PEAK && evenSin == SIN0));

  assert_odd_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2 && $past(highSpeed, 2) && !$past(oddNegate, 2) && $past(phaseInc, 2) == 0)
    |-> (oddCos == evenCos && oddSin == evenSin));

  assert_odd_negated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2 && $past(highSpeed, 2) && $past(oddNegate, 2) && $past(phaseInc, 2) == 0)
    |-> (oddCos == -evenCos && oddSin == -evenSin));

  assert_no_min_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evenCos != MOST_NEG && evenSin != MOST_NEG && oddCos != MOST_NEG && oddSin != MOST_NEG));
endmodule

bind dual_phase_nco dual_phase_nco_chk #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) chk_i (.*);

// File: tb/dual_phase_nco_tb_top.sv
module dual_phase_nco_tb_top;
  localparam int ADDR_W = 13;
  localparam int PEAK   = 2047;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic [31:0] phaseInc = '0;
  logic highSpeed = 1'b0;
  logic oddNegate = 1'b0;
  logic signed [11:0] evenCos, evenSin, oddCos, oddSin;

  always #2 clk = ~clk;

  dual_phase_nco dut_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .phaseInc(phaseInc),
    .highSpeed(highSpeed), .oddNegate(oddNegate),
    .evenCos(evenCos), .evenSin(evenSin), .oddCos(oddCos), .oddSin(oddSin)
  );

  int nCompared = 0;
  int nMismatch = 0;
  bit finished = 0;

  typedef struct {
    int ec; int es; int oc; int os;
    bit hs; bit neg; bit v;
    string extra;
  } exp_t;

  exp_t pend1, pend2;
  logic [31:0] mAcc;

  function automatic int refLook(input logic [ADDR_W-1:0] a, input bit isCos);
    real ang;
    ang = 6.283185307179586 * (real'(a) + 0.5) / real'(1 << ADDR_W);
    return isCos ? int'(real'(PEAK) * $cos(ang)) : int'(real'(PEAK) * $sin(ang));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nMismatch++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic printSummary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
  endtask

  // One clock: drive at negedge, model the edge, check after it
  task automatic runCycle(input logic [31:0] inc, input bit s, input bit hs, input bit neg,
                          input string extra);
    exp_t e;
    logic signed [31:0] half;
    logic [31:0] oPh;
    sync = s; phaseInc = inc; highSpeed = hs; oddNegate = neg;
    half = $signed(inc) >>> 1;
    oPh  = mAcc + $unsigned(half);
    e.ec = refLook(mAcc[31:19], 1'b1);
    e.es = refLook(mAcc[31:19], 1'b0);
    e.oc = hs ? (neg ? -refLook(oPh[31:19], 1'b1) : refLook(oPh[31:19], 1'b1)) : 0;
    e.os = hs ? (neg ? -refLook(oPh[31:19], 1'b0) : refLook(oPh[31:19], 1'b0)) : 0;
    e.hs = hs; e.neg = neg; e.v = 1'b1; e.extra = extra;
    mAcc = s ? 32'd0 : mAcc + inc;
    pend2 = pend1;
    pend1 = e;
    @(posedge clk);
    @(negedge clk);
    if (pend2.v) begin
      string oTag;
      oTag = pend2.hs ? (pend2.neg ? "R7" : "R5") : (pend2.neg ? "R7 R6" : "R6");
      chk({"R1 R2 R3 evenCos ", pend2.extra}, int'(evenCos), pend2.ec);
      chk({"R1 R2 R3 evenSin ", pend2.extra}, int'(evenSin), pend2.es);
      chk({oTag, " oddCos ", pend2.extra}, int'(oddCos), pend2.oc);
      chk({oTag, " oddSin ", pend2.extra}, int'(oddSin), pend2.os);
      chk("R9 no most-negative output",
          int'(evenCos == -2048 || evenSin == -2048 || oddCos == -2048 || oddSin == -2048), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nMismatch++;
      $display("FAIL watchdog expired");
      printSummary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    pend1.v = 1'b0;
    pend2.v = 1'b0;
    mAcc = '0;
    highSpeed = 1'b1;
    phaseInc = 32'h1234_5678;
    repeat (4) @(negedge clk);
    // R8: outputs held at zero in reset
    chk("R8 evenCos in reset", int'(evenCos), 0);
    chk("R8 evenSin in reset", int'(evenSin), 0);
    chk("R8 oddCos in reset", int'(oddCos), 0);
    chk("R8 oddSin in reset", int'(oddSin), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) runCycle(32'h1000_0000, 0, 1, 0, "coarse step");
    for (int i = 0; i < 8; i++)  runCycle(32'h0, 0, 1, 1, "zero step negate");
    for (int i = 0; i < 8; i++)  runCycle(32'h0, 0, 1, 0, "zero step");
    for (int i = 0; i < 12; i++) runCycle(32'hFFFF_FFFF, 0, 1, 0, "minus one step");
    for (int i = 0; i < 8; i++)  runCycle(32'hFFF0_0000, 0, 1, 1, "negative step negate");
    for (int i = 0; i < 8; i++)  runCycle(32'h4000_0000, 0, 1, 0, "quarter turn");
    for (int i = 0; i < 8; i++)  runCycle(32'h7FFF_FFFF, 0, 1, 1, "max positive");
    for (int i = 0; i < 8; i++)  runCycle(32'h8000_0000, 0, 1, 0, "half turn");
    // R4: sync clear in the middle of a run
    runCycle(32'h0567_89AB, 0, 1, 0, "R4 before sync");
    runCycle(32'h0567_89AB, 1, 1, 0, "R4 sync edge");
    for (int i = 0; i < 4; i++) runCycle(32'h0567_89AB, 0, 1, 0, "R4 after sync");
    // R6 and R7: negate ignored in normal mode
    for (int i = 0; i < 10; i++) runCycle(32'h0ABC_DEF1, 0, 0, 1, "normal mode negate");
    for (int i = 0; i < 6; i++)  runCycle(32'h0ABC_DEF1, 0, 0, 0, "normal mode");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] inc;
      inc = $urandom();
      if ($urandom_range(0, 3) == 0) inc = inc >> $urandom_range(4, 20);
      runCycle(inc, $urandom_range(0, 49) == 0, 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), "random");
    end
    runCycle(32'h0, 0, 0, 0, "drain");
    runCycle(32'h0, 0, 0, 0, "drain");

    finished = 1;
    printSummary();
    $finish;
  end
endmodule